// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line interrupt channels, a primary and a secondary, into one sixteen-line requester for a processor. Each channel keeps its own request, in-service, mask and trigger-mode registers and its own fixed-priority resolver. A qualifying request on the secondary channel is forwarded onto primary line 2. The primary channel's resolver alone drives the processor request output.

When the processor answers with an acknowledge pulse, the sequencer picks the winner from the state held before that clock edge and moves it into service. One cycle later it presents an 8-bit vector number and the 4-bit global line index, qualified by a valid strobe. If primary line 2 wins, the acknowledge moves down into the secondary channel. At either level, when nothing qualifies, the sequencer answers with line 7 of that level as a spurious vector. Software loads the vector base, mask and trigger mode of a channel through one configuration write port. It retires a line from service with a specific end-of-interrupt command that names the global line index.

Top module: `irq_casc_seq`

## Requirements
- R1: After reset, int_req and ack_valid are 0, every line is unmasked and edge-triggered, and both vector bases are 0.
- R2: An edge-triggered line (trigger bit 0) latches a request on a 0-to-1 change of its input, and acknowledging it clears the request. A held-high input does not latch again. A level-triggered line (trigger bit 1) requests while its input is 1, and acknowledging it does not clear the request.
- R3: Within a channel, a lower line index has higher priority. A pending unmasked line qualifies only if its priority is strictly higher than that of every in-service line of the same channel.
- R4: int_req is 1 exactly when the primary channel has a qualifying line. External input bit 2 is ignored. A qualifying secondary line sets an edge request on primary line 2 one cycle after it qualifies.
- R5: ack_valid is 1 in the cycle after a cycle with ack = 1, and 0 otherwise.
- R6: On ack, a primary winner other than line 2 goes into service. The result is vector = primary base + line and index = line.
- R7: On ack with primary line 2 winning, primary line 2 goes into service. If the secondary channel has a winner s, that line goes into service too, and the result is vector = secondary base + s and index = s + 8.
- R8: On ack with primary line 2 winning and no secondary winner, the result is vector = secondary base + 7 and index = 15. The secondary channel's state is left unchanged.
- R9: On ack with no primary winner, the result is vector = primary base + 7 and index = 7, and no channel state changes.
- R10: On a configuration write, the vector base stores the written value with its low 3 bits forced to 0.
- R11: An end-of-interrupt command with global index g clears the in-service bit of line g mod 8 in the primary channel (g < 8) or in the secondary channel (g >= 8).
- R12: If primary line 2 is level-triggered, forwarding from the secondary channel never latches a request on it.
- R13: A masked line (mask bit 1) keeps its latched request but does not qualify. Clearing the mask bit lets it qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request inputs, bits 0-7 primary, bits 8-15 secondary |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Channel selected for the write: 0 primary, 1 secondary |
| cfg_base | input | 8 | Vector base (low 3 bits discarded) |
| cfg_mask | input | 8 | Mask bits, 1 = masked |
| cfg_level | input | 8 | Trigger mode bits, 1 = level, 0 = edge |
| ack | input | 1 | Acknowledge pulse from the processor |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_idx | input | 4 | Global line index to retire from service |
| int_req | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Acknowledge result strobe |
| ack_vector | output | 8 | Vector number of the acknowledged line |
| ack_index | output | 4 | Global line index of the acknowledged line |

## Verification
The bench builds the block with eight lines per channel and the cascade on primary line 2, the only width for which the vector base alignment and the spurious line 7 appear as written. With these values one test walks every acknowledge path: a direct primary line, a descent to a secondary line, a secondary spurious answer after a level-triggered secondary request drops while its forwarded edge is still latched, and a primary spurious answer. They also expose the two-cycle delay of a forwarded secondary request and the effect of making the cascade line level-triggered.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    localparam int VEC_W = 8;

    typedef logic [LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t             irr;
        line_vec_t             isr;
        line_vec_t             last;
        line_vec_t             imr;
        line_vec_t             level;
        logic [VEC_W-1:0]      base;
    } chan_t;

    typedef struct packed {
        chan_t                 m;
        chan_t                 s;
        logic                  ack_valid;
        logic [VEC_W-1:0]      vector;
        logic [IDX_W:0]        index;
    } seq_state_t;
endpackage

// File: rtl/irq_casc_resolver.sv
module irq_casc_resolver
    import irq_casc_pkg::*;
(
    input  line_vec_t        irr,
    input  line_vec_t        isr,
    input  line_vec_t        imr,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    line_vec_t        req;
    logic             r_any;
    logic             s_any;
    logic [IDX_W-1:0] r_idx;
    logic [IDX_W-1:0] s_idx;

    always_comb begin
        req   = irr & ~imr;
        r_any = 1'b0;
        s_any = 1'b0;
        r_idx = '0;
        s_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                r_any = 1'b1;
                r_idx = IDX_W'(i);
            end
            if (isr[i]) begin
                s_any = 1'b1;
                s_idx = IDX_W'(i);
            end
        end
        valid = r_any && (!s_any || (r_idx < s_idx));
        idx   = r_idx;
    end
endmodule

// File: rtl/irq_casc_chan_next.sv
module irq_casc_chan_next
    import irq_casc_pkg::*;
(
    input  line_vec_t raw,
    input  line_vec_t pulse,
    input  line_vec_t level,
    input  line_vec_t irr_q,
    input  line_vec_t isr_q,
    input  line_vec_t last_q,
    input  line_vec_t ack_set,
    input  line_vec_t eoi_clr,
    output line_vec_t irr_d,
    output line_vec_t isr_d,
    output line_vec_t last_d
);
    line_vec_t edge_req;
    line_vec_t lvl_req;

    always_comb begin
        // pulse-driven lines rise and fall inside one update: last stays 0
        edge_req = (irr_q & ~ack_set) | (raw & ~last_q);
        lvl_req  = raw & ~pulse;
        irr_d    = (level & lvl_req) | (~level & edge_req);
        last_d   = raw & ~pulse;
        isr_d    = (isr_q & ~eoi_clr) | ack_set;
    end
endmodule

// File: rtl/irq_casc_seq.sv
module irq_casc_seq
    import irq_casc_pkg::*;
#(
    parameter int CASC_LINE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*LINES-1:0] irq_lines,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [VEC_W-1:0]   cfg_base,
    input  logic [LINES-1:0]   cfg_mask,
    input  logic [LINES-1:0]   cfg_level,
    input  logic               ack,
    input  logic               eoi_valid,
    input  logic [IDX_W:0]     eoi_idx,
    output logic               int_req,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vector,
    output logic [IDX_W:0]     ack_index
);
    localparam logic [IDX_W-1:0] CASC_IDX  = IDX_W'(CASC_LINE);
    localparam logic [IDX_W-1:0] SPUR_IDX  = IDX_W'(LINES - 1);
    localparam logic [VEC_W-1:0] BASE_KEEP = ~VEC_W'(LINES - 1);

    seq_state_t q, d;

    logic             m_valid, s_valid;
    logic [IDX_W-1:0] m_idx, s_idx;
    logic             take_m, via_casc, take_s, cascade;
    line_vec_t        m_raw, s_raw, m_pulse;
    line_vec_t        m_ack_set, s_ack_set, m_eoi, s_eoi;
    line_vec_t        m_irr_d, m_isr_d, m_last_d;
    line_vec_t        s_irr_d, s_isr_d, s_last_d;

    irq_casc_resolver u_res_m (
        .irr(q.m.irr), .isr(q.m.isr), .imr(q.m.imr),
        .valid(m_valid), .idx(m_idx)
    );

    irq_casc_resolver u_res_s (
        .irr(q.s.irr), .isr(q.s.isr), .imr(q.s.imr),
        .valid(s_valid), .idx(s_idx)
    );

    always_comb begin
        take_m   = ack && m_valid;
        via_casc = take_m && (m_idx == CASC_IDX);
        take_s   = via_casc && s_valid;
        // the acknowledged secondary request must not re-latch the cascade line
        cascade  = s_valid && !via_casc;

        m_raw             = irq_lines[LINES-1:0];
        m_raw[CASC_LINE]  = cascade | (irq_lines[CASC_LINE] & 1'b0);
        s_raw             = irq_lines[2*LINES-1:LINES];
        m_pulse           = line_vec_t'(1) << CASC_IDX;

        m_ack_set = take_m ? (line_vec_t'(1) << m_idx) : '0;
        s_ack_set = take_s ? (line_vec_t'(1) << s_idx) : '0;
        m_eoi     = (eoi_valid && !eoi_idx[IDX_W]) ? (line_vec_t'(1) << eoi_idx[IDX_W-1:0]) : '0;
        s_eoi     = (eoi_valid &&  eoi_idx[IDX_W]) ? (line_vec_t'(1) << eoi_idx[IDX_W-1:0]) : '0;
    end

    irq_casc_chan_next u_nxt_m (
        .raw(m_raw), .pulse(m_pulse), .level(q.m.level),
        .irr_q(q.m.irr), .isr_q(q.m.isr), .last_q(q.m.last),
        .ack_set(m_ack_set), .eoi_clr(m_eoi),
        .irr_d(m_irr_d), .isr_d(m_isr_d), .last_d(m_last_d)
    );

    irq_casc_chan_next u_nxt_s (
        .raw(s_raw), .pulse('0), .level(q.s.level),
        .irr_q(q.s.irr), .isr_q(q.s.isr), .last_q(q.s.last),
        .ack_set(s_ack_set), .eoi_clr(s_eoi),
        .irr_d(s_irr_d), .isr_d(s_isr_d), .last_d(s_last_d)
    );

    always_comb begin
        d = q;
        d.m.irr  = m_irr_d;
        d.m.isr  = m_isr_d;
        d.m.last = m_last_d;
        d.s.irr  = s_irr_d;
        d.s.isr  = s_isr_d;
        d.s.last = s_last_d;

        if (cfg_we) begin
            if (cfg_sel) begin
                d.s.imr   = cfg_mask;
                d.s.level = cfg_level;
                d.s.base  = cfg_base & BASE_KEEP;
            end else begin
                d.m.imr   = cfg_mask;
                d.m.level = cfg_level;
                d.m.base  = cfg_base & BASE_KEEP;
            end
        end

        d.ack_valid = ack;
        if (ack) begin
            if (!m_valid) begin
                d.vector = q.m.base + VEC_W'(SPUR_IDX);
                d.index  = {1'b0, SPUR_IDX};
            end else if (!via_casc) begin
                d.vector = q.m.base + VEC_W'(m_idx);
                d.index  = {1'b0, m_idx};
            end else if (take_s) begin
                d.vector = q.s.base + VEC_W'(s_idx);
                d.index  = {1'b1, s_idx};
            end else begin
                d.vector = q.s.base + VEC_W'(SPUR_IDX);
                d.index  = {1'b1, SPUR_IDX};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign int_req    = m_valid;
    assign ack_valid  = q.ack_valid;
    assign ack_vector = q.vector;
    assign ack_index  = q.index;
endmodule

// File: rtl/irq_casc_chk.sv
module irq_casc_chk
    import irq_casc_pkg::*;
#(
    parameter int CASC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             int_req,
    input logic             ack_valid,
    input logic [VEC_W-1:0] ack_vector,
    input logic [IDX_W:0]   ack_index
);
    localparam logic [IDX_W:0] SPUR_G = (IDX_W+1)'(LINES - 1);
    localparam logic [IDX_W:0] CASC_G = (IDX_W+1)'(CASC);

    a_r5_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_valid);

    a_r5_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !ack_valid);

    a_r10_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_vector[IDX_W-1:0] == ack_index[IDX_W-1:0]));

    a_r9_spurious_primary: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_req) |=> (ack_index == SPUR_G));

    a_r7_cascade_never_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_req) |=> (ack_index != CASC_G));
endmodule

bind irq_casc_seq irq_casc_chk #(.CASC(CASC_LINE)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .int_req(int_req),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .ack_index(ack_index)
);

// File: tb/tb_irq_casc_seq.sv
module tb_irq_casc_seq;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_lines;
    logic        cfg_we, cfg_sel;
    logic [7:0]  cfg_base, cfg_mask, cfg_level;
    logic        ack, eoi_valid;
    logic [3:0]  eoi_idx;
    logic        int_req, ack_valid;
    logic [7:0]  ack_vector;
    logic [3:0]  ack_index;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_casc_seq #(.CASC_LINE(2)) dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .cfg_level(cfg_level),
        .ack(ack), .eoi_valid(eoi_valid), .eoi_idx(eoi_idx),
        .int_req(int_req), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .ack_index(ack_index)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input bit sel, input int base, input int mask, input int lvl);
        cfg_we = 1'b1; cfg_sel = sel;
        cfg_base = 8'(base); cfg_mask = 8'(mask); cfg_level = 8'(lvl);
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic eoi(input int g);
        eoi_valid = 1'b1; eoi_idx = 4'(g);
        tick(1);
        eoi_valid = 1'b0;
    endtask

    task automatic do_ack(input string req, input int vec, input int idx);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        chk({req, " valid"}, int'(ack_valid), 1);
        chk({req, " vector"}, int'(ack_vector), vec);
        chk({req, " index"}, int'(ack_index), idx);
        tick(1);
        chk("R5 valid drops", int'(ack_valid), 0);
    endtask

    task automatic t_reset;
        chk("R1 int_req", int'(int_req), 0);
        chk("R1 ack_valid", int'(ack_valid), 0);
        irq_lines[2] = 1'b1;               // R4: external bit 2 ignored
        tick(3);
        chk("R4 bit2 ignored", int'(int_req), 0);
        irq_lines[2] = 1'b0;
        do_ack("R9 spurious at reset base", 8'h07, 7);
    endtask

    task automatic t_base;
        cfg(0, 8'h23, 0, 0);
        cfg(1, 8'h75, 0, 0);
        do_ack("R10 base aligned", 8'h27, 7);
    endtask

    task automatic t_master;
        irq_lines[5] = 1'b1; tick(1);
        chk("R4 req on line5", int'(int_req), 1);
        do_ack("R6 line5", 8'h25, 5);
        chk("R2 edge cleared", int'(int_req), 0);
        tick(2);
        chk("R2 held high no relatch", int'(int_req), 0);
        irq_lines[0] = 1'b1; tick(1);
        chk("R3 higher preempts", int'(int_req), 1);
        do_ack("R6 line0", 8'h20, 0);
        irq_lines[6] = 1'b1; tick(1);
        chk("R3 lower blocked", int'(int_req), 0);
        eoi(0); tick(1);
        chk("R11 eoi0 still blocked by 5", int'(int_req), 0);
        eoi(5); tick(1);
        chk("R11 eoi5 unblocks", int'(int_req), 1);
        do_ack("R6 line6", 8'h26, 6);
        eoi(6);
        irq_lines = '0; tick(1);
        chk("R4 idle", int'(int_req), 0);
    endtask

    task automatic t_priority;
        irq_lines[3] = 1'b1; irq_lines[1] = 1'b1; tick(1);
        do_ack("R3 lowest index first", 8'h21, 1);
        chk("R3 line3 blocked by 1", int'(int_req), 0);
        eoi(1); tick(1);
        do_ack("R3 line3 after eoi", 8'h23, 3);
        eoi(3);
        irq_lines = '0; tick(1);
    endtask

    task automatic t_mask;
        cfg(0, 8'h20, 8'h10, 0);
        irq_lines[4] = 1'b1; tick(2);
        chk("R13 masked", int'(int_req), 0);
        cfg(0, 8'h20, 0, 0); tick(1);
        chk("R13 unmasked kept request", int'(int_req), 1);
        do_ack("R13 line4", 8'h24, 4);
        eoi(4);
        irq_lines = '0; tick(1);
    endtask

    task automatic t_level;
        cfg(0, 8'h20, 0, 8'h40);
        irq_lines[6] = 1'b1; tick(1);
        do_ack("R2 level line6", 8'h26, 6);
        eoi(6); tick(1);
        chk("R2 level stays", int'(int_req), 1);
        irq_lines[6] = 1'b0; tick(1);
        chk("R2 level follows input", int'(int_req), 0);
        cfg(0, 8'h20, 0, 0);
    endtask

    task automatic t_slave;
        irq_lines[11] = 1'b1; tick(1);
        chk("R4 forward delay", int'(int_req), 0);
        tick(1);
        chk("R4 forwarded", int'(int_req), 1);
        do_ack("R7 slave line3", 8'h73, 11);
        chk("R7 both in service", int'(int_req), 0);
        eoi(11); eoi(2);
        irq_lines = '0; tick(2);
        chk("R11 idle after two eoi", int'(int_req), 0);
    endtask

    task automatic t_slave_spurious;
        cfg(1, 8'h70, 0, 8'h02);
        irq_lines[9] = 1'b1; tick(2);
        chk("R4 level slave forwarded", int'(int_req), 1);
        irq_lines[9] = 1'b0; tick(1);
        chk("R4 cascade edge sticky", int'(int_req), 1);
        do_ack("R8 slave spurious", 8'h77, 15);
        chk("R8 master line2 in service", int'(int_req), 0);
        irq_lines[8] = 1'b1; tick(3);
        chk("R8 blocked by master isr2", int'(int_req), 0);
        eoi(2); tick(1);
        chk("R11 eoi2 releases", int'(int_req), 1);
        do_ack("R8 slave untouched", 8'h70, 8);
        eoi(8); eoi(2);
        irq_lines = '0;
        cfg(1, 8'h70, 0, 0);
    endtask

    task automatic t_casc_level;
        cfg(0, 8'h20, 0, 8'h04);
        irq_lines[10] = 1'b1; tick(3);
        chk("R12 level cascade no latch", int'(int_req), 0);
        cfg(0, 8'h20, 0, 0); tick(1);
        chk("R12 edge cascade latches", int'(int_req), 1);
        do_ack("R7 slave line2", 8'h72, 10);
        eoi(10); eoi(2);
        irq_lines = '0; tick(1);
    endtask

    initial begin
        rst_n = 1'b0; irq_lines = '0; cfg_we = 1'b0; cfg_sel = 1'b0;
        cfg_base = '0; cfg_mask = '0; cfg_level = '0;
        ack = 1'b0; eoi_valid = 1'b0; eoi_idx = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_base();
        t_master();
        t_priority();
        t_mask();
        t_level();
        t_slave();
        t_slave_spurious();
        t_casc_level();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule